// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Secure Routing

This block collects 128 level-sensitive interrupt lines and turns them into two processor requests: a normal interrupt request (`irqOut`) and a fast interrupt request (`fiqOut`). The lines are arranged in four groups of 32. Source n sits in group n/32 at bit n%32. Each source has an enable bit, a routing bit and an 8-bit priority byte. A source takes part only when its line is high, its enable bit is set, and the upper nibble of its priority byte is strictly below the upper nibble of a global threshold.

Software reaches all state through a single-cycle word-addressed register port. A write takes effect at the clock edge where `wrEn` is high. Read data is combinational and is valid in the same cycle as `rdEn`. The address is a 6-bit word index:

- control at 0x00;
- threshold at 0x01;
- enable-set at 0x04..0x07;
- enable-clear at 0x08..0x0B;
- routing at 0x0C..0x0F;
- pending at 0x10..0x13;
- priority words at 0x20..0x3F.

Each group address block is indexed by group number. All other addresses read zero, and writes to them are ignored.

Top module: `intc_top`

## Requirements
- R1: After reset both outputs are low, and all of the following read back zero: control, threshold, every enable word, every routing word and every priority word.
- R2: A write to enable-set address 0x04+g sets the enable bits of group g where the write data is 1 and leaves the others unchanged. Reading either 0x04+g or 0x08+g returns the enable vector of group g.
- R3: A write to enable-clear address 0x08+g clears the enable bits of group g where the write data is 1 and leaves the others unchanged.
- R4: Reading pending address 0x10+g returns the bitwise AND of the group g input lines and the group g enables, with no latching. Writes to the pending addresses change nothing.
- R5: The priority byte of source n is held in word 0x20+n/4 at bits [(n%4)*8 +: 8]. It is written and read back in full.
- R6: A source is eligible only if its line is high, it is enabled, and bits [7:4] of its priority byte are strictly less than bits [7:4] of the threshold (address 0x01, bits [7:0]). The low nibbles of both bytes are ignored.
- R7: Routing bit n of word 0x0C+g set to 1 sends that source to `irqOut`. Set to 0, it sends the source to `fiqOut`.
- R8: Control bit 0 is the global enable; while it is 0 neither output asserts. Control bit 1 enables the non-secure path; `irqOut` additionally needs it to be 1, and `fiqOut` does not depend on it.
- R9: Each output is a register. It is high in the cycle after some eligible source is routed to it with its path enabled, and it drops in the cycle after that stops being true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, zero when rdEn is low |
| srcIn | input | 128 | Level-sensitive interrupt lines, bit n is source n |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast (secure) interrupt request |

## Verification
The bench targets the threshold edge. A priority nibble equal to the threshold nibble must not qualify. Priority 0x3F against threshold 0x40 must qualify and 0x40 against 0x4F must not, which exposes a design that compares the full byte or uses less-or-equal. Writes that mix ones and zeros to the set and clear words are read back, so a design that overwrites rather than merges its enable state would return the wrong vector. Random sources are driven in every group with mixed routing, which would catch a wrong group index, a swapped routing polarity or a priority byte slotted into the wrong lane. The bench also drops the global and non-secure enables and watches the one-cycle assert and release, so an output that ignores the control bits or is off by one cycle shows up.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_MASK,
    RD_ENABLE,
    RD_SEC,
    RD_PEND,
    RD_PRIO
  } rdKind_t;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic    ctrlWr;
    logic    maskWr;
    logic    setWr;
    logic    clrWr;
    logic    secWr;
    logic    prioWr;
    rdKind_t rdKind;
    logic [7:0] idx;
  } strobe_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SET_BASE  = ADDR_W'(NUM_GROUPS);
  localparam logic [ADDR_W-1:0] CLR_BASE  = ADDR_W'(2 * NUM_GROUPS);
  localparam logic [ADDR_W-1:0] SEC_BASE  = ADDR_W'(3 * NUM_GROUPS);
  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(4 * NUM_GROUPS);
  localparam logic [ADDR_W-1:0] PEND_END  = ADDR_W'(5 * NUM_GROUPS);
  localparam logic [ADDR_W-1:0] PRIO_BASE = ADDR_W'(8 * NUM_GROUPS);

  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    if (addr == ADDR_CTRL) begin
      stb.ctrlWr = wrEn;
      if (rdEn) stb.rdKind = RD_CTRL;
    end else if (addr == ADDR_MASK) begin
      stb.maskWr = wrEn;
      if (rdEn) stb.rdKind = RD_MASK;
    end else if (addr >= SET_BASE && addr < CLR_BASE) begin
      stb.setWr = wrEn;
      stb.idx   = 8'(addr - SET_BASE);
      if (rdEn) stb.rdKind = RD_ENABLE;
    end else if (addr >= CLR_BASE && addr < SEC_BASE) begin
      stb.clrWr = wrEn;
      stb.idx   = 8'(addr - CLR_BASE);
      if (rdEn) stb.rdKind = RD_ENABLE;
    end else if (addr >= SEC_BASE && addr < PEND_BASE) begin
      stb.secWr = wrEn;
      stb.idx   = 8'(addr - SEC_BASE);
      if (rdEn) stb.rdKind = RD_SEC;
    end else if (addr >= PEND_BASE && addr < PEND_END) begin
      stb.idx = 8'(addr - PEND_BASE);
      if (rdEn) stb.rdKind = RD_PEND;
    end else if (addr >= PRIO_BASE) begin
      stb.prioWr = wrEn;
      stb.idx    = 8'(addr - PRIO_BASE);
      if (rdEn) stb.rdKind = RD_PRIO;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  parameter int PRIO_W     = 8,
  parameter int CMP_W      = 4,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W,
  localparam int PER_WORD  = GROUP_W / PRIO_W,
  localparam int NUM_PWORD = NUM_SRC / PER_WORD,
  localparam int GI_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int PI_W      = (NUM_PWORD > 1) ? $clog2(NUM_PWORD) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  strobe_t                            stb,
  input  logic [GROUP_W-1:0]                 wrData,
  input  logic [NUM_SRC-1:0]                 srcIn,
  output logic [GROUP_W-1:0]                 rdData,
  output logic                               irqOut,
  output logic                               fiqOut,
  output logic [NUM_GROUPS-1:0][GROUP_W-1:0] enVec,
  output logic                               globalEn,
  output logic                               irqPathEn,
  output logic [PRIO_W-1:0]                  maskVal
);
  logic [1:0]                         ctrlReg;
  logic [PRIO_W-1:0]                  maskReg;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] enReg;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] secReg;
  logic [NUM_SRC-1:0][PRIO_W-1:0]     prioReg;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] srcGrp;
  logic [NUM_SRC-1:0]                 eligible;
  logic [GI_W-1:0]                    gIdx;
  logic [PI_W-1:0]                    pIdx;
  logic                               irqNext;
  logic                               fiqNext;

  assign srcGrp = srcIn;
  assign gIdx   = stb.idx[GI_W-1:0];
  assign pIdx   = stb.idx[PI_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      maskReg <= '0;
      enReg   <= '0;
      secReg  <= '0;
      prioReg <= '0;
    end else begin
      if (stb.ctrlWr) ctrlReg <= wrData[1:0];
      if (stb.maskWr) maskReg <= wrData[PRIO_W-1:0];
      if (stb.setWr) enReg[gIdx] <= enReg[gIdx] | wrData;
      if (stb.clrWr) enReg[gIdx] <= enReg[gIdx] & ~wrData;
      if (stb.secWr) secReg[gIdx] <= wrData;
      if (stb.prioWr) begin
        for (int k = 0; k < PER_WORD; k++)
          prioReg[{pIdx, 2'(k)}] <= wrData[k*PRIO_W +: PRIO_W];
      end
    end
  end

  // Threshold comparison on the upper bits of each priority byte
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
    assign eligible[n] = srcGrp[n / GROUP_W][n % GROUP_W] &
                         enReg[n / GROUP_W][n % GROUP_W] &
                         (prioReg[n][PRIO_W-1 -: CMP_W] < maskReg[PRIO_W-1 -: CMP_W]);
  end

  always_comb begin
    irqNext = ctrlReg[0] & ctrlReg[1] & |(eligible & secReg);
    fiqNext = ctrlReg[0] & |(eligible & ~secReg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= irqNext;
      fiqOut <= fiqNext;
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.rdKind)
      RD_CTRL:   rdData = GROUP_W'(ctrlReg);
      RD_MASK:   rdData = GROUP_W'(maskReg);
      RD_ENABLE: rdData = enReg[gIdx];
      RD_SEC:    rdData = secReg[gIdx];
      RD_PEND:   rdData = srcGrp[gIdx] & enReg[gIdx];
      RD_PRIO: begin
        for (int k = 0; k < PER_WORD; k++)
          rdData[k*PRIO_W +: PRIO_W] = prioReg[{pIdx, 2'(k)}];
      end
      default:   rdData = '0;
    endcase
  end

  assign enVec     = enReg;
  assign globalEn  = ctrlReg[0];
  assign irqPathEn = ctrlReg[1];
  assign maskVal   = maskReg;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  parameter int PRIO_W     = 8,
  parameter int CMP_W      = 4,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W,
  localparam int ADDR_W    = $clog2(16 * NUM_GROUPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [GROUP_W-1:0] wrData,
  output logic [GROUP_W-1:0] rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);
  strobe_t                            stb;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] enVec;
  logic                               globalEn;
  logic                               irqPathEn;
  logic [PRIO_W-1:0]                  maskVal;

  intc_decode #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W(ADDR_W)
  ) decodeInst (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb(stb)
  );

  intc_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_W(GROUP_W),
    .PRIO_W(PRIO_W),
    .CMP_W(CMP_W)
  ) dataInst (
    .clk(clk),
    .rst(rst),
    .stb(stb),
    .wrData(wrData),
    .srcIn(srcIn),
    .rdData(rdData),
    .irqOut(irqOut),
    .fiqOut(fiqOut),
    .enVec(enVec),
    .globalEn(globalEn),
    .irqPathEn(irqPathEn),
    .maskVal(maskVal)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  parameter int PRIO_W     = 8,
  parameter int ADDR_W     = 6
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               wrEn,
  input logic                               rdEn,
  input logic [ADDR_W-1:0]                  addr,
  input logic [GROUP_W-1:0]                 wrData,
  input logic [GROUP_W-1:0]                 rdData,
  input logic                               irqOut,
  input logic                               fiqOut,
  input logic [NUM_GROUPS-1:0][GROUP_W-1:0] enVec,
  input logic                               globalEn,
  input logic                               irqPathEn,
  input logic [PRIO_W-1:0]                  maskVal
);
  localparam int GI_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic isSet, isClr, isPend;
  assign isSet  = addr >= ADDR_W'(NUM_GROUPS) && addr < ADDR_W'(2 * NUM_GROUPS);
  assign isClr  = addr >= ADDR_W'(2 * NUM_GROUPS) && addr < ADDR_W'(3 * NUM_GROUPS);
  assign isPend = addr >= ADDR_W'(4 * NUM_GROUPS) && addr < ADDR_W'(5 * NUM_GROUPS);

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isSet) |=>
      ((enVec[$past(addr[GI_W-1:0])] & $past(wrData)) == $past(wrData)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isClr) |=> ((enVec[$past(addr[GI_W-1:0])] & $past(wrData)) == '0));

  // R4
  pend_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && isPend) |-> ((rdData & ~enVec[addr[GI_W-1:0]]) == '0));

  // R6
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(maskVal[PRIO_W-1 -: 4]) == 4'd0) |-> (!irqOut && !fiqOut));

  // R8
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(globalEn) |-> (!irqOut && !fiqOut));

  // R8
  irq_path_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(globalEn && irqPathEn));
endmodule

bind intc_top intc_checker chk (
  .clk(clk),
  .rst(rst),
  .wrEn(wrEn),
  .rdEn(rdEn),
  .addr(addr),
  .wrData(wrData),
  .rdData(rdData),
  .irqOut(irqOut),
  .fiqOut(fiqOut),
  .enVec(enVec),
  .globalEn(globalEn),
  .irqPathEn(irqPathEn),
  .maskVal(maskVal)
);

// File: tb/intc_top_test.sv
`timescale 1ns/1ps
module intc_top_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [127:0] srcIn = '0;
  logic         irqOut, fiqOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] mEn [4];
  logic [31:0] mSec [4];
  logic [7:0]  mPrio [128];
  logic [7:0]  mMask;
  logic [1:0]  mCtrl;

  intc_top uut (.*);

  always #4 clk = ~clk;

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 6'h00) mCtrl = d[1:0];
    else if (a == 6'h01) mMask = d[7:0];
    else if (a >= 6'h04 && a < 6'h08) mEn[a[1:0]] |= d;
    else if (a >= 6'h08 && a < 6'h0C) mEn[a[1:0]] &= ~d;
    else if (a >= 6'h0C && a < 6'h10) mSec[a[1:0]] = d;
    else if (a >= 6'h20)
      for (int k = 0; k < 4; k++) mPrio[{a[4:0], 2'(k)}] = d[k*8 +: 8];
  endtask

  task automatic regRead(logic [5:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    #1;
    d = rdData;
    rdEn = 1'b0;
  endtask

  function automatic logic [1:0] expOut();
    logic irq = 1'b0, fiq = 1'b0;
    for (int n = 0; n < 128; n++) begin
      if (srcIn[n] && mEn[n/32][n%32] && (mPrio[n][7:4] < mMask[7:4])) begin
        if (mSec[n/32][n%32]) irq = 1'b1; else fiq = 1'b1;
      end
    end
    return {irq & mCtrl[0] & mCtrl[1], fiq & mCtrl[0]};
  endfunction

  // one clock edge passes, then the registered outputs are compared
  task automatic checkOut(string req);
    @(negedge clk);
    chk(req, {30'b0, irqOut, fiqOut}, {30'b0, expOut()});
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    for (int g = 0; g < 4; g++) begin mEn[g] = '0; mSec[g] = '0; end
    for (int n = 0; n < 128; n++) mPrio[n] = '0;
    mMask = '0; mCtrl = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {30'b0, irqOut, fiqOut}, 32'd0);
    regRead(6'h00, v); chk("R1 control", v, 32'd0);
    regRead(6'h01, v); chk("R1 threshold", v, 32'd0);
    for (int g = 0; g < 4; g++) begin
      regRead(6'h04 + 6'(g), v); chk("R1 enable", v, 32'd0);
      regRead(6'h0C + 6'(g), v); chk("R1 routing", v, 32'd0);
    end
    regRead(6'h3F, v); chk("R1 priority", v, 32'd0);

    // R2 / R3 merge semantics
    regWrite(6'h05, 32'hF0F0_00FF);
    regWrite(6'h05, 32'h0000_0F00);
    regRead(6'h05, v); chk("R2 set merge", v, 32'hF0F0_0FFF);
    regRead(6'h09, v); chk("R2 clear addr readback", v, 32'hF0F0_0FFF);
    regWrite(6'h09, 32'h00F0_000F);
    regRead(6'h05, v); chk("R3 clear merge", v, 32'hF000_0FF0);

    // R5 priority packing
    regWrite(6'h20 + 6'd9, 32'h4433_2211);
    regRead(6'h29, v); chk("R5 word readback", v, 32'h4433_2211);

    // R4 pending follows lines, write ignored
    srcIn = '0; srcIn[32 + 4] = 1'b1; srcIn[32 + 0] = 1'b1; srcIn[32 + 28] = 1'b1;
    #1; regRead(6'h11, v); chk("R4 pending", v, 32'h1000_0010);
    regWrite(6'h11, 32'hFFFF_FFFF);
    regRead(6'h11, v); chk("R4 pending write ignored", v, 32'h1000_0010);
    srcIn[32 + 28] = 1'b0;
    #1; regRead(6'h11, v); chk("R4 pending no latch", v, 32'h0000_0010);
    regWrite(6'h09, 32'hFFFF_FFFF);
    srcIn = '0;

    // R6 threshold edge, source 36 = word 9 lane 0
    regWrite(6'h00, 32'h3);
    regWrite(6'h0D, 32'h0);        // group 1 to fast path
    regWrite(6'h05, 32'h0000_0010);
    regWrite(6'h29, 32'h0000_003F);
    regWrite(6'h01, 32'h40);
    srcIn[36] = 1'b1;
    checkOut("R6 below threshold");
    chk("R6 fiq asserted", {31'b0, fiqOut}, 32'd1);
    regWrite(6'h01, 32'h3F);
    checkOut("R6 equal nibble blocked");
    chk("R6 fiq low", {31'b0, fiqOut}, 32'd0);
    regWrite(6'h29, 32'h0000_0040);
    regWrite(6'h01, 32'h4F);
    checkOut("R6 low nibble ignored");
    regWrite(6'h29, 32'h0000_002F);
    checkOut("R6 reopen");

    // R7 routing
    regWrite(6'h0D, 32'h0000_0010);
    checkOut("R7 routed to irq");
    chk("R7 irq high", {30'b0, irqOut, fiqOut}, 32'd2);

    // R8 control bits
    regWrite(6'h00, 32'h1);
    checkOut("R8 irq path off");
    chk("R8 irq low", {31'b0, irqOut}, 32'd0);
    regWrite(6'h0D, 32'h0);
    checkOut("R8 fiq ignores path bit");
    regWrite(6'h00, 32'h2);
    checkOut("R8 global off");
    chk("R8 nothing out", {30'b0, irqOut, fiqOut}, 32'd0);
    regWrite(6'h00, 32'h3);

    // R9 one-cycle assert and release
    checkOut("R9 asserted");
    @(negedge clk); srcIn[36] = 1'b0;
    #1; chk("R9 still high before edge", {31'b0, fiqOut}, 32'd1);
    checkOut("R9 released");

    // random mix across all groups
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: regWrite(6'h04 + 6'($urandom_range(0, 3)), $urandom());
        1: regWrite(6'h08 + 6'($urandom_range(0, 3)), $urandom() & $urandom());
        2: regWrite(6'h0C + 6'($urandom_range(0, 3)), $urandom());
        3: regWrite(6'h20 + 6'($urandom_range(0, 31)), $urandom());
        4: regWrite(6'h01, 32'($urandom_range(0, 255)) | 32'h80);
        5: if ($urandom_range(0, 3) == 0) regWrite(6'h00, 32'($urandom_range(0, 3)));
        default: ;
      endcase
      @(negedge clk);
      srcIn = {$urandom(), $urandom(), $urandom(), $urandom()} &
              {$urandom(), $urandom(), $urandom(), $urandom()};
      if (it % 8 == 0) srcIn = '0;
      checkOut("R6 R7 R8 random outputs");
      if (it % 5 == 0) begin
        int g;
        g = int'($urandom_range(0, 3));
        regRead(6'h10 + 6'(g), v); chk("R4 random pending", v, srcIn[g*32 +: 32] & mEn[g]);
        regRead(6'h04 + 6'(g), v); chk("R2 random enable", v, mEn[g]);
      end
      if (it % 7 == 0) begin
        int w;
        w = int'($urandom_range(0, 31));
        regRead(6'h20 + 6'(w), v);
        chk("R5 random priority", v,
            {mPrio[w*4+3], mPrio[w*4+2], mPrio[w*4+1], mPrio[w*4]});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule